// File: doc/BRIEF.md
# Thermal Threshold Interrupt Unit

This block watches a stream of 8-bit raw temperature codes from an on-chip sensor and turns them into interrupts. Each accepted sample is compared with three programmable interrupt levels, each of which has its own rising and falling threshold. When a sample crosses a threshold, the block latches a pending flag for that level and direction. A fourth threshold drives a hardware trip output. That output stays asserted until the block is reset.

Software reaches the unit through a flat word-addressed register port. The port holds a rising-threshold word, a falling-threshold word, an interrupt enable word, a write-one-to-clear interrupt word, a control word and the latest temperature code. The combined interrupt line is high whenever an enabled pending flag is set. In normal use only the rising interrupts of levels 1 and 2 are enabled and the falling thresholds stay at zero.

Top module: `thermal_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero except control, which reads 0x0060_0000 (sensor select 3'b110). `irq_o` and `trip_o` are low.
- R2: Register map by word address: 0 holds the rising thresholds (32 bits, level k in byte k, trip code in byte 3), 1 holds the falling thresholds (32 bits, level k in byte k), 2 holds the enables (only bits 0, 4, 8, 16, 20 and 24 are stored), 4 holds control (only bits 0, 12 and 22:20 are stored), 5 holds the code and is read-only, and addresses 6 and 7 read zero.
- R3: A sample is accepted when `samp_valid` is high while core enable (control bit 0) is set. The code of an accepted sample reads from bits [7:0] of address 5 after the next clock edge. The register reads zero until the first sample is accepted.
- R4: For each level k, an accepted sample sets the rising flag at bit 4k when the sample is greater than or equal to byte k of the rising word and the previous accepted code (zero after reset) was below it.
- R5: For each level k, an accepted sample sets the falling flag at bit 16+4k when the previous code was greater than or equal to byte k of the falling word and the sample is below it. A zero falling threshold never fires.
- R6: Reading address 3 returns the pending flags at the enable bit positions. Writing ones to address 3 clears the matching flags. A flag that is set in the same cycle as its clear stays set.
- R7: `irq_o` is high exactly when some pending flag has its enable bit set. It follows a write to the enable register or to the clear register on the next edge.
- R8: An accepted sample sets `trip_o` on the next edge when control bits 0 and 12 are both set and the sample is greater than or equal to byte 3 of the rising word. `trip_o` then stays high until reset, even if the enables are cleared.
- R9: While core enable is clear, samples change neither the code register, the pending flags nor `trip_o`.
- R10: Pending flags are set whether or not their enable bit is set. The enables gate only `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| samp_valid | input | 1 | Sample strobe from the sensor |
| samp_code | input | 8 | Raw temperature code |
| irq_o | output | 1 | Combined interrupt line |
| trip_o | output | 1 | Sticky hardware trip output |

## Verification
Register writes, sample acceptance, pending flags and the trip latch all take effect on the clock edge that sees the stimulus. `reg_rdata` and `irq_o` are combinational views of that state. Every result is therefore due one edge after its stimulus. The bench drives inputs just after the falling edge, lets one rising edge pass, and compares read data, `irq_o` and `trip_o` with its model 1 ns later. Reads that need no edge are checked 1 ns after the address changes.

// File: rtl/thermal_irq_pkg.sv
// Shared constants for the thermal threshold interrupt unit.
// Assumes a 32-bit register word and a word-addressed register port.
package thermal_irq_pkg;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 3;

    localparam logic [ADDR_W-1:0] ADDR_RISE = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_FALL = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_EN   = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_CLR  = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_CODE = 3'd5;

    localparam int CTRL_CORE_BIT = 0;
    localparam int CTRL_TRIP_BIT = 12;
    localparam int CTRL_MUX_LSB  = 20;
    localparam int CTRL_MUX_W    = 3;
    localparam logic [CTRL_MUX_W-1:0] MUX_RESET = 3'b110;

    localparam int RISE_FLAG_LSB = 0;
    localparam int FALL_FLAG_LSB = 16;
    localparam int FLAG_STRIDE   = 4;

    // Build the mask of flag positions used by n levels.
    function automatic logic [DATA_W-1:0] flag_mask(input int n);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int k = 0; k < n; k++) begin
            m[RISE_FLAG_LSB + FLAG_STRIDE*k] = 1'b1;
            m[FALL_FLAG_LSB + FLAG_STRIDE*k] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/tiu_regfile.sv
// Configuration registers and read multiplexer.
// Holds the thresholds, enables and control word. Turns writes to the
// clear address into a one-cycle clear mask. Reads are combinational.
// Assumes (N_LVL+1)*CODE_W <= DATA_W and N_LVL <= 4.
module tiu_regfile
    import thermal_irq_pkg::*;
#(
    parameter int N_LVL  = 3,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [CODE_W-1:0] cur_code,
    input  logic [DATA_W-1:0] pend,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] rise_thr,
    output logic [DATA_W-1:0] fall_thr,
    output logic [DATA_W-1:0] irq_en,
    output logic [DATA_W-1:0] clr_bits,
    output logic              core_en,
    output logic              trip_en
);
    localparam logic [DATA_W-1:0] FLAGS = flag_mask(N_LVL);

    logic [CTRL_MUX_W-1:0] mux_sel;
    logic                  wr_rise, wr_fall, wr_en, wr_clr, wr_ctrl;

    // Decode the write strobe into one enable per register.
    always_comb begin
        wr_rise = reg_we && (reg_addr == ADDR_RISE);
        wr_fall = reg_we && (reg_addr == ADDR_FALL);
        wr_en   = reg_we && (reg_addr == ADDR_EN);
        wr_clr  = reg_we && (reg_addr == ADDR_CLR);
        wr_ctrl = reg_we && (reg_addr == ADDR_CTRL);
    end

    // Threshold words are stored as full words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_thr <= '0;
            fall_thr <= '0;
        end else begin
            if (wr_rise) rise_thr <= reg_wdata;
            if (wr_fall) fall_thr <= reg_wdata;
        end
    end

    // The enable word keeps only the defined flag positions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= '0;
        end else if (wr_en) begin
            irq_en <= reg_wdata & FLAGS;
        end
    end

    // Control fields: core enable, trip enable, sensor select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_en <= 1'b0;
            trip_en <= 1'b0;
            mux_sel <= MUX_RESET;
        end else if (wr_ctrl) begin
            core_en <= reg_wdata[CTRL_CORE_BIT];
            trip_en <= reg_wdata[CTRL_TRIP_BIT];
            mux_sel <= reg_wdata[CTRL_MUX_LSB +: CTRL_MUX_W];
        end
    end

    // A write of ones to the clear address becomes a one-cycle clear mask.
    always_comb clr_bits = wr_clr ? (reg_wdata & FLAGS) : '0;

    // Combinational read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_RISE: reg_rdata = rise_thr;
            ADDR_FALL: reg_rdata = fall_thr;
            ADDR_EN:   reg_rdata = irq_en;
            ADDR_CLR:  reg_rdata = pend;
            ADDR_CTRL: begin
                reg_rdata[CTRL_CORE_BIT] = core_en;
                reg_rdata[CTRL_TRIP_BIT] = trip_en;
                reg_rdata[CTRL_MUX_LSB +: CTRL_MUX_W] = mux_sel;
            end
            ADDR_CODE: reg_rdata[CODE_W-1:0] = cur_code;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tiu_level_cmp.sv
// Crossing detector for one level.
// Compares the previous and the new code with the rising and the falling
// threshold. Purely combinational. The caller qualifies the result with
// sample acceptance.
module tiu_level_cmp #(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] prev_code,
    input  logic [CODE_W-1:0] new_code,
    input  logic [CODE_W-1:0] rise_lvl,
    input  logic [CODE_W-1:0] fall_lvl,
    output logic              rise_hit,
    output logic              fall_hit
);
    // Upward crossing: below before, at or above now. Downward is the mirror.
    always_comb begin
        rise_hit = (prev_code < rise_lvl) && (new_code >= rise_lvl);
        fall_hit = (prev_code >= fall_lvl) && (new_code < fall_lvl);
    end
endmodule

// File: rtl/tiu_event_ctrl.sv
// Sample acceptance, pending flags, trip latch and combined interrupt.
// The stored current code doubles as the previous sample for the crossing
// tests. A set event wins over a clear in the same cycle.
module tiu_event_ctrl
    import thermal_irq_pkg::*;
#(
    parameter int N_LVL  = 3,
    parameter int CODE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    samp_valid,
    input  logic [CODE_W-1:0]       samp_code,
    input  logic                    core_en,
    input  logic                    trip_en,
    input  logic [DATA_W-1:0]       rise_thr,
    input  logic [N_LVL*CODE_W-1:0] fall_thr,
    input  logic [DATA_W-1:0]       irq_en,
    input  logic [DATA_W-1:0]       clr_bits,
    output logic [CODE_W-1:0]       cur_code,
    output logic [DATA_W-1:0]       pend,
    output logic                    irq,
    output logic                    trip
);
    localparam int TRIP_LSB = N_LVL * CODE_W;

    logic              accept;
    logic [N_LVL-1:0]  rise_hit, fall_hit;
    logic [DATA_W-1:0] set_bits;
    logic [CODE_W-1:0] trip_code;

    // A sample counts only while the core is enabled.
    always_comb accept = samp_valid && core_en;

    // One crossing detector per level.
    for (genvar k = 0; k < N_LVL; k++) begin : g_lvl
        tiu_level_cmp #(.CODE_W(CODE_W)) u_cmp (
            .prev_code (cur_code),
            .new_code  (samp_code),
            .rise_lvl  (rise_thr[k*CODE_W +: CODE_W]),
            .fall_lvl  (fall_thr[k*CODE_W +: CODE_W]),
            .rise_hit  (rise_hit[k]),
            .fall_hit  (fall_hit[k])
        );
    end

    // Place the qualified hits at their flag positions.
    always_comb begin
        set_bits = '0;
        for (int k = 0; k < N_LVL; k++) begin
            set_bits[RISE_FLAG_LSB + FLAG_STRIDE*k] = accept && rise_hit[k];
            set_bits[FALL_FLAG_LSB + FLAG_STRIDE*k] = accept && fall_hit[k];
        end
    end

    // Store the latest accepted code.
    always_ff @(posedge clk) begin
        if (!rst_n)      cur_code <= '0;
        else if (accept) cur_code <= samp_code;
    end

    // Pending flags: clear first, then set, so a new event is not lost.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_bits) | set_bits;
    end

    // Sticky hardware trip.
    always_comb trip_code = rise_thr[TRIP_LSB +: CODE_W];
    always_ff @(posedge clk) begin
        if (!rst_n)
            trip <= 1'b0;
        else if (accept && trip_en && (samp_code >= trip_code))
            trip <= 1'b1;
    end

    // Combined interrupt from enabled pending flags.
    always_comb irq = |(pend & irq_en);
endmodule

// File: rtl/thermal_irq_unit.sv
// Top level of the thermal threshold interrupt unit.
// Connects the register file to the event controller. Assumes samples
// arrive as a single-cycle valid/code pair and that register reads are
// taken combinationally from reg_addr.
module thermal_irq_unit
    import thermal_irq_pkg::*;
#(
    parameter int N_LVL  = 3,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              samp_valid,
    input  logic [CODE_W-1:0] samp_code,
    output logic              irq_o,
    output logic              trip_o
);
    logic [DATA_W-1:0] rise_thr, fall_thr, irq_en, clr_bits, pend;
    logic [CODE_W-1:0] cur_code;
    logic              core_en, trip_en;

    tiu_regfile #(.N_LVL(N_LVL), .CODE_W(CODE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cur_code  (cur_code),
        .pend      (pend),
        .reg_rdata (reg_rdata),
        .rise_thr  (rise_thr),
        .fall_thr  (fall_thr),
        .irq_en    (irq_en),
        .clr_bits  (clr_bits),
        .core_en   (core_en),
        .trip_en   (trip_en)
    );

    tiu_event_ctrl #(.N_LVL(N_LVL), .CODE_W(CODE_W)) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .samp_valid (samp_valid),
        .samp_code  (samp_code),
        .core_en    (core_en),
        .trip_en    (trip_en),
        .rise_thr   (rise_thr),
        .fall_thr   (fall_thr[N_LVL*CODE_W-1:0]),
        .irq_en     (irq_en),
        .clr_bits   (clr_bits),
        .cur_code   (cur_code),
        .pend       (pend),
        .irq        (irq_o),
        .trip       (trip_o)
    );
endmodule

// File: rtl/tiu_checker.sv
// Temporal checks for the thermal threshold interrupt unit.
// Bound to the top level and observing its ports and internal state.
module tiu_checker
    import thermal_irq_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              samp_valid,
    input logic [CODE_W-1:0] samp_code,
    input logic              core_en,
    input logic              trip_en,
    input logic [CODE_W-1:0] cur_code,
    input logic [DATA_W-1:0] pend,
    input logic              irq_o,
    input logic              trip_o
);
    // Once set, the trip output holds until reset.
    assert_trip_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trip_o |=> trip_o);

    // The trip output rises only after an accepted sample with trip enabled.
    assert_trip_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_o) |-> $past(samp_valid && core_en && trip_en));

    // A sample with the core off leaves the stored code alone.
    assert_core_off_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_valid && !core_en) |=> $stable(cur_code));

    // An accepted sample is stored.
    assert_code_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_valid && core_en) |=> (cur_code == $past(samp_code)));

    // Flags are set only by accepted samples.
    assert_no_set_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(samp_valid && core_en) |=> ((pend & ~$past(pend)) == '0));

    // A clear with no sample removes the addressed flags.
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_addr == ADDR_CLR) && !(samp_valid && core_en))
        |=> ((pend & $past(reg_wdata)) == '0));

    // No interrupt without a pending flag.
    assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> !irq_o);
endmodule

bind thermal_irq_unit tiu_checker #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .samp_valid (samp_valid),
    .samp_code  (samp_code),
    .core_en    (core_en),
    .trip_en    (trip_en),
    .cur_code   (cur_code),
    .pend       (pend),
    .irq_o      (irq_o),
    .trip_o     (trip_o)
);

// File: tb/thermal_irq_unit_bench.sv
`timescale 1ns/1ps
module thermal_irq_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        samp_valid = 1'b0;
    logic [7:0]  samp_code = '0;
    logic        irq_o, trip_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [31:0] FMASK = 32'h0111_0111;

    // Reference model state.
    logic [31:0] m_rise, m_fall, m_en, m_pend;
    logic        m_core, m_ten, m_trip;
    logic [2:0]  m_mux;
    logic [7:0]  m_cur;

    always #2.5 clk = ~clk;

    thermal_irq_unit u_thermal_irq_unit (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .samp_valid(samp_valid),
        .samp_code(samp_code), .irq_o(irq_o), .trip_o(trip_o)
    );

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_rise;
            3'd1: return m_fall;
            3'd2: return m_en;
            3'd3: return m_pend;
            3'd4: return {9'd0, m_mux, 7'd0, m_ten, 11'd0, m_core};
            3'd5: return {24'd0, m_cur};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] a);
        if (a == 3'd3) return "R6";
        if (a == 3'd5) return "R3";
        return "R2";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_rise = '0; m_fall = '0; m_en = '0; m_pend = '0;
        m_core = 0; m_ten = 0; m_trip = 0; m_mux = 3'b110; m_cur = '0;
    endtask

    // One clock: drive inputs, advance the model, check 1 ns after the edge.
    task automatic cyc(input logic we, input logic [2:0] a, input logic [31:0] wd,
                       input logic sv, input logic [7:0] sc);
        logic        acc;
        logic [31:0] setb, clr;
        reg_we = we; reg_addr = a; reg_wdata = wd; samp_valid = sv; samp_code = sc;
        acc  = sv && m_core;
        setb = '0;
        if (acc) begin
            for (int k = 0; k < 3; k++) begin
                if (m_cur < m_rise[8*k +: 8] && sc >= m_rise[8*k +: 8]) setb[4*k] = 1'b1;
                if (m_cur >= m_fall[8*k +: 8] && sc < m_fall[8*k +: 8]) setb[16+4*k] = 1'b1;
            end
        end
        clr = (we && a == 3'd3) ? (wd & FMASK) : '0;
        @(posedge clk);
        #1;
        if (acc && m_ten && sc >= m_rise[31:24]) m_trip = 1'b1;
        m_pend = (m_pend & ~clr) | setb;
        if (acc) m_cur = sc;
        if (we) begin
            case (a)
                3'd0: m_rise = wd;
                3'd1: m_fall = wd;
                3'd2: m_en = wd & FMASK;
                3'd4: begin m_core = wd[0]; m_ten = wd[12]; m_mux = wd[22:20]; end
                default: ;
            endcase
        end
        check(req_of(a), reg_rdata, model_read(a));
        check("R7", {31'd0, irq_o}, {31'd0, |(m_pend & m_en)});
        check("R8", {31'd0, trip_o}, {31'd0, m_trip});
        @(negedge clk);
        reg_we = 1'b0; samp_valid = 1'b0;
    endtask

    // Read without a clock edge.
    task automatic expect_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
        reg_we = 1'b0; reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
        check(req, reg_rdata, model_read(a));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        reg_we = 0; samp_valid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        do_reset();

        // R1 reset state
        for (int a = 0; a < 8; a++)
            expect_reg("R1", 3'(a), (a == 4) ? 32'h0060_0000 : 32'h0);
        check("R1", {30'd0, irq_o, trip_o}, 32'd0);

        // R2 field masks and read-only code register
        cyc(1, 3'd2, 32'hFFFF_FFFF, 0, 0);
        expect_reg("R2", 3'd2, 32'h0111_0111);
        cyc(1, 3'd4, 32'hFFFF_FFFF, 0, 0);
        expect_reg("R2", 3'd4, 32'h0070_1001);
        cyc(1, 3'd5, 32'hFFFF_FFFF, 0, 0);
        expect_reg("R2", 3'd5, 32'h0);
        cyc(1, 3'd2, 32'h0, 0, 0);

        // Setup: core on, trip off
        cyc(1, 3'd4, 32'h0060_0001, 0, 0);
        cyc(1, 3'd0, 32'hF060_4020, 0, 0);
        cyc(1, 3'd1, 32'h0050_3818, 0, 0);

        // R3 code load
        expect_reg("R3", 3'd5, 32'h0);
        cyc(0, 3'd5, 0, 1, 8'h10);
        expect_reg("R3", 3'd5, 32'h10);

        // R4 rising crossings, including an exact hit and a repeated sample
        cyc(0, 3'd3, 0, 1, 8'h30);
        expect_reg("R4", 3'd3, 32'h0000_0001);
        cyc(0, 3'd3, 0, 1, 8'h30);
        expect_reg("R4", 3'd3, 32'h0000_0001);
        cyc(0, 3'd3, 0, 1, 8'h40);
        expect_reg("R4", 3'd3, 32'h0000_0011);
        cyc(0, 3'd3, 0, 1, 8'h70);
        expect_reg("R4", 3'd3, 32'h0000_0111);

        // R10 flags set with enables off; R7 irq follows the enables
        check("R10", {31'd0, irq_o}, 32'd0);
        cyc(1, 3'd2, 32'h0000_0010, 0, 0);
        check("R7", {31'd0, irq_o}, 32'd1);

        // R5 falling crossings on all levels
        cyc(0, 3'd3, 0, 1, 8'h10);
        expect_reg("R5", 3'd3, 32'h0111_0111);

        // R6 clear all, then set wins over a same-cycle clear
        cyc(1, 3'd3, 32'hFFFF_FFFF, 0, 0);
        expect_reg("R6", 3'd3, 32'h0);
        check("R7", {31'd0, irq_o}, 32'd0);
        cyc(1, 3'd3, 32'h0000_0001, 1, 8'h30);
        expect_reg("R6", 3'd3, 32'h0000_0001);

        // R9 core off: sample ignored even with trip enabled
        cyc(1, 3'd4, 32'h0060_1000, 0, 0);
        cyc(0, 3'd5, 0, 1, 8'hFF);
        expect_reg("R9", 3'd5, 32'h30);
        expect_reg("R9", 3'd3, 32'h0000_0001);
        check("R9", {31'd0, trip_o}, 32'd0);

        // R8 trip below, at the level, then sticky after the enables drop
        cyc(1, 3'd4, 32'h0060_1001, 0, 0);
        cyc(0, 3'd5, 0, 1, 8'hEF);
        check("R8", {31'd0, trip_o}, 32'd0);
        cyc(0, 3'd5, 0, 1, 8'hF0);
        check("R8", {31'd0, trip_o}, 32'd1);
        cyc(1, 3'd4, 32'h0, 0, 0);
        cyc(0, 3'd5, 0, 1, 8'h00);
        check("R8", {31'd0, trip_o}, 32'd1);

        do_reset();
        check("R1", {31'd0, trip_o}, 32'd0);

        // Random phase
        cyc(1, 3'd4, 32'h0060_1001, 0, 0);
        cyc(1, 3'd0, 32'hFF80_5030, 0, 0);
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            logic        we;
            logic [2:0]  a;
            logic [31:0] wd;
            r  = $urandom % 100;
            we = (r < 20);
            a  = 3'($urandom % 8);
            wd = $urandom;
            if (we && a == 3'd4) wd[0] = ($urandom % 4) != 0;
            if (we && a == 3'd0 && ($urandom % 2)) wd[31:24] = 8'hFF;
            cyc(we, a, wd, ($urandom % 3) != 0, 8'($urandom));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule